// File: doc/BRIEF.md
# Streaming Ethernet Transmit Framer

This block turns a stream of sample bytes into Ethernet frames and sends them one nibble per clock over the MII transmit pins to an external PHY. It is meant for a dedicated full-duplex 100BASE-TX link. Such a link never has collisions, so the block never senses carrier and never backs off. It waits until the upstream FIFO holds a whole payload and then sends the frame in one go: preamble and start delimiter, a broadcast header carrying a configured source address and EtherType, the payload bytes, and a CRC-32 check sequence. After each frame it holds an inter-frame gap before it may start again.

The FIFO is read in first-word-fall-through style. `fifo_data` shows the head byte, and a one-cycle `fifo_rd` pulse consumes it. If the FIFO reports empty in the middle of a payload, the block sends a zero byte in that slot and sets a sticky error flag. It also complements the check sequence, so the receiver drops the damaged frame. The configuration inputs are read while the header goes out, so they must only change between frames.

Top module: `eth_stream_tx`

## Requirements
- R1: While reset (`rst_n` low) is applied, `mii_tx_en`, `mii_txd`, `fifo_rd` and `err_underflow` are all 0.
- R2: A frame starts only when `fifo_level` is at least PAYLOAD_LEN; with fewer bytes waiting, `mii_tx_en` stays low indefinitely.
- R3: A frame begins with seven 0x55 bytes followed by 0xD5. Every byte of the frame is sent low nibble first. `mii_tx_en` stays high for exactly 2*(26+PAYLOAD_LEN) consecutive clocks per frame.
- R4: The 14 header bytes are six 0xFF bytes, then `cfg_src_mac[47:40]` down to `cfg_src_mac[7:0]`, then `cfg_ethertype[15:8]` and `cfg_ethertype[7:0]`.
- R5: The payload is PAYLOAD_LEN bytes taken from `fifo_data` in FIFO order, with exactly one `fifo_rd` pulse per byte and never two pulses on adjacent clocks.
- R6: The last four bytes form the IEEE 802.3 CRC-32 over header and payload (reflected polynomial 0xEDB88320, start value all ones, final complement), least significant byte first.
- R7: After a frame, `mii_tx_en` stays low for at least IFG_CLKS clocks. If a full payload is already waiting when the frame ends, the next frame starts after exactly IFG_CLKS+1 low clocks.
- R8: If `fifo_empty` is high when a payload byte is due, the block sends 0x00 in that slot, does not pulse `fifo_rd`, and sets `err_underflow`. The frame keeps its full length, and its four check bytes are the bitwise complement of the correct CRC-32 field for the bytes actually sent.
- R9: `err_underflow` stays set until reset. Later frames with no underflow carry a correct check sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | MII transmit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_level | input | LVL_W | Number of bytes held in the upstream FIFO |
| fifo_data | input | 8 | Head byte of the FIFO (first-word-fall-through) |
| fifo_empty | input | 1 | FIFO has no byte to give |
| fifo_rd | output | 1 | Consume the head byte at this clock edge |
| cfg_src_mac | input | 48 | Source address placed in the header |
| cfg_ethertype | input | 16 | EtherType placed in the header |
| mii_txd | output | 4 | Transmit nibble to the PHY |
| mii_tx_en | output | 1 | Transmit enable to the PHY |
| err_underflow | output | 1 | Sticky flag: a payload byte was missing |

## Verification
The assertions take for granted that `fifo_empty` only goes high when the FIFO really has nothing to give. In particular, `fifo_rd` is never expected while it is high. They also assume the configuration inputs stay steady for the length of a frame. The bench models the FIFO as a byte queue whose level and head byte follow its real contents. All FIFO and configuration changes are made just after a clock edge, and the configuration is changed only while the link is idle. Underflow is produced by forcing `fifo_empty` high for a fixed window in mid-payload, which starves exactly three byte fetches.

// File: rtl/eth_stream_pkg.sv
package eth_stream_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_HDR,
        ST_PAY,
        ST_FCS,
        ST_GAP
    } tx_state_e;

    localparam logic [7:0]  PRE_BYTE      = 8'h55;
    localparam logic [7:0]  SFD_BYTE      = 8'hD5;
    localparam int          PRE_BYTES     = 8;
    localparam int          HDR_BYTES     = 14;
    localparam int          FCS_NIBS      = 8;
    localparam logic [31:0] CRC_SEED      = 32'hFFFF_FFFF;
    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;

endpackage

// File: rtl/eth_crc_nib.sv
module eth_crc_nib (
    input  logic [31:0] crc_in,
    input  logic [3:0]  nib,
    output logic [31:0] crc_out
);
    import eth_stream_pkg::*;

    always_comb begin
        logic [31:0] c;
        logic        fb;
        c = crc_in;
        for (int i = 0; i < 4; i++) begin
            fb = c[0] ^ nib[i];
            c  = c >> 1;
            if (fb) begin
                c = c ^ CRC_POLY_REFL;
            end
        end
        crc_out = c;
    end
endmodule

// File: rtl/eth_hdr_byte.sv
module eth_hdr_byte (
    input  logic [3:0]  idx,
    input  logic [47:0] src_mac,
    input  logic [15:0] ethertype,
    output logic [7:0]  hdr_byte
);
    logic [7:0] src_bytes [6];

    for (genvar g = 0; g < 6; g++) begin : g_src
        assign src_bytes[g] = src_mac[47 - 8*g -: 8];
    end

    always_comb begin
        if (idx < 4'd6) begin
            hdr_byte = 8'hFF;
        end else if (idx < 4'd12) begin
            hdr_byte = src_bytes[3'(idx - 4'd6)];
        end else if (idx == 4'd12) begin
            hdr_byte = ethertype[15:8];
        end else begin
            hdr_byte = ethertype[7:0];
        end
    end
endmodule

// File: rtl/eth_fcs_nib.sv
module eth_fcs_nib (
    input  logic [31:0] crc,
    input  logic [2:0]  sel,
    input  logic        corrupt,
    output logic [3:0]  nib
);
    logic [3:0] raw;

    assign raw = crc[4*sel +: 4];
    assign nib = corrupt ? raw : ~raw;
endmodule

// File: rtl/eth_stream_tx.sv
module eth_stream_tx #(
    parameter int PAYLOAD_LEN = 46,
    parameter int IFG_CLKS    = 24,
    parameter int LVL_W       = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LVL_W-1:0]  fifo_level,
    input  logic [7:0]        fifo_data,
    input  logic              fifo_empty,
    output logic              fifo_rd,
    input  logic [47:0]       cfg_src_mac,
    input  logic [15:0]       cfg_ethertype,
    output logic [3:0]        mii_txd,
    output logic              mii_tx_en,
    output logic              err_underflow
);
    import eth_stream_pkg::*;

    localparam int CNT_MAX = (PAYLOAD_LEN > IFG_CLKS) ? PAYLOAD_LEN : IFG_CLKS;
    localparam int CNT_W   = $clog2(CNT_MAX + HDR_BYTES + 1);

    localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(PRE_BYTES - 1);
    localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_BYTES - 1);
    localparam logic [CNT_W-1:0] PAY_LAST = CNT_W'(PAYLOAD_LEN - 1);
    localparam logic [CNT_W-1:0] FCS_LAST = CNT_W'(FCS_NIBS - 1);
    localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(IFG_CLKS - 1);
    localparam logic [LVL_W-1:0] LVL_NEED = LVL_W'(PAYLOAD_LEN);

    typedef struct packed {
        tx_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic             ph;
        logic [7:0]       hold;
        logic [31:0]      crc;
        logic [3:0]       txd;
        logic             txen;
        logic             err;
        logic             bad;
    } tx_regs_t;

    tx_regs_t cur_q, nxt_d;

    logic [7:0]  hdr_b;
    logic [7:0]  src_b;
    logic [3:0]  nib_out;
    logic [31:0] crc_upd;
    logic [3:0]  fcs_n;
    logic        rd_d;

    eth_hdr_byte u_hdr (
        .idx       (cur_q.cnt[3:0]),
        .src_mac   (cfg_src_mac),
        .ethertype (cfg_ethertype),
        .hdr_byte  (hdr_b)
    );

    eth_crc_nib u_crc (
        .crc_in  (cur_q.crc),
        .nib     (nib_out),
        .crc_out (crc_upd)
    );

    eth_fcs_nib u_fcs (
        .crc     (cur_q.crc),
        .sel     (cur_q.cnt[2:0]),
        .corrupt (cur_q.bad),
        .nib     (fcs_n)
    );

    // Byte source for the nibble-serialised sections of the frame.
    always_comb begin
        case (cur_q.st)
            ST_PRE:  src_b = (cur_q.cnt == PRE_LAST) ? SFD_BYTE : PRE_BYTE;
            ST_HDR:  src_b = hdr_b;
            ST_PAY:  src_b = fifo_empty ? 8'h00 : fifo_data;
            default: src_b = 8'h00;
        endcase
    end

    // Low nibble comes from the live byte, high nibble from the held copy.
    assign nib_out = cur_q.ph ? cur_q.hold[7:4] : src_b[3:0];

    always_comb begin
        nxt_d = cur_q;
        rd_d  = 1'b0;

        case (cur_q.st)
            ST_IDLE: begin
                nxt_d.txen = 1'b0;
                nxt_d.txd  = 4'h0;
                if (fifo_level >= LVL_NEED) begin
                    nxt_d.st  = ST_PRE;
                    nxt_d.cnt = '0;
                    nxt_d.ph  = 1'b0;
                    nxt_d.bad = 1'b0;
                end
            end

            ST_PRE, ST_HDR, ST_PAY: begin
                nxt_d.txen = 1'b1;
                nxt_d.txd  = nib_out;
                nxt_d.ph   = ~cur_q.ph;
                if (cur_q.st != ST_PRE) begin
                    nxt_d.crc = crc_upd;
                end
                if (!cur_q.ph) begin
                    nxt_d.hold = src_b;
                    if (cur_q.st == ST_PAY) begin
                        if (fifo_empty) begin
                            nxt_d.err = 1'b1;
                            nxt_d.bad = 1'b1;
                        end else begin
                            rd_d = 1'b1;
                        end
                    end
                end else begin
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                    case (cur_q.st)
                        ST_PRE: begin
                            if (cur_q.cnt == PRE_LAST) begin
                                nxt_d.st  = ST_HDR;
                                nxt_d.cnt = '0;
                                nxt_d.crc = CRC_SEED;
                            end
                        end
                        ST_HDR: begin
                            if (cur_q.cnt == HDR_LAST) begin
                                nxt_d.st  = ST_PAY;
                                nxt_d.cnt = '0;
                            end
                        end
                        default: begin
                            if (cur_q.cnt == PAY_LAST) begin
                                nxt_d.st  = ST_FCS;
                                nxt_d.cnt = '0;
                            end
                        end
                    endcase
                end
            end

            ST_FCS: begin
                nxt_d.txen = 1'b1;
                nxt_d.txd  = fcs_n;
                nxt_d.cnt  = cur_q.cnt + 1'b1;
                if (cur_q.cnt == FCS_LAST) begin
                    nxt_d.st  = ST_GAP;
                    nxt_d.cnt = '0;
                end
            end

            ST_GAP: begin
                nxt_d.txen = 1'b0;
                nxt_d.txd  = 4'h0;
                nxt_d.cnt  = cur_q.cnt + 1'b1;
                if (cur_q.cnt == GAP_LAST) begin
                    nxt_d.st  = ST_IDLE;
                    nxt_d.cnt = '0;
                end
            end

            default: begin
                nxt_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.st   <= ST_IDLE;
            cur_q.cnt  <= '0;
            cur_q.ph   <= 1'b0;
            cur_q.hold <= 8'h00;
            cur_q.crc  <= CRC_SEED;
            cur_q.txd  <= 4'h0;
            cur_q.txen <= 1'b0;
            cur_q.err  <= 1'b0;
            cur_q.bad  <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign fifo_rd       = rd_d & rst_n;
    assign mii_txd       = cur_q.txd;
    assign mii_tx_en     = cur_q.txen;
    assign err_underflow = cur_q.err;

endmodule

// File: rtl/eth_stream_tx_chk.sv
module eth_stream_tx_chk #(
    parameter int PAYLOAD_LEN = 46,
    parameter int IFG_CLKS    = 24
) (
    input logic       clk,
    input logic       rst_n,
    input logic       fifo_empty,
    input logic       fifo_rd,
    input logic [3:0] mii_txd,
    input logic       mii_tx_en,
    input logic       err_underflow
);
    localparam int FRAME_NIBS = 2 * (26 + PAYLOAD_LEN);
    localparam int NW         = $clog2(FRAME_NIBS + IFG_CLKS + 2) + 1;

    logic [NW-1:0] low_run;
    logic [NW-1:0] high_run;
    logic          had_frame;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run   <= '0;
            high_run  <= '0;
            had_frame <= 1'b0;
        end else if (mii_tx_en) begin
            low_run   <= '0;
            high_run  <= high_run + 1'b1;
            had_frame <= 1'b1;
        end else begin
            high_run <= '0;
            if (low_run != '1) begin
                low_run <= low_run + 1'b1;
            end
        end
    end

    // R7: gap between frames
    a_r7_gap_min: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mii_tx_en) && had_frame) |-> (low_run >= NW'(IFG_CLKS)));

    // R3: frame length in nibbles
    a_r3_frame_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mii_tx_en) |-> (high_run == NW'(FRAME_NIBS)));

    // R3: first nibble on the wire is the preamble pattern
    a_r3_first_nibble: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mii_tx_en) |-> (mii_txd == 4'h5));

    // R5: pops are spaced and fall inside a frame
    a_r5_pop_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |=> !fifo_rd);

    a_r5_pop_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> mii_tx_en);

    // R8: no pop from an empty FIFO
    a_r8_no_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> !fifo_empty);

    // R9: error flag is sticky
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_underflow |=> err_underflow);

endmodule

bind eth_stream_tx eth_stream_tx_chk #(
    .PAYLOAD_LEN (PAYLOAD_LEN),
    .IFG_CLKS    (IFG_CLKS)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fifo_empty    (fifo_empty),
    .fifo_rd       (fifo_rd),
    .mii_txd       (mii_txd),
    .mii_tx_en     (mii_tx_en),
    .err_underflow (err_underflow)
);

// File: tb/sim_eth_stream_tx.sv
module sim_eth_stream_tx;
    localparam int PAY = 46;
    localparam int IFG = 24;
    localparam int LW  = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [LW-1:0] fifo_level = '0;
    logic [7:0]    fifo_data = 8'h00;
    logic          fifo_empty = 1'b1;
    logic          fifo_rd;
    logic [47:0]   cfg_src_mac = 48'h0;
    logic [15:0]   cfg_ethertype = 16'h0;
    logic [3:0]    mii_txd;
    logic          mii_tx_en;
    logic          err_underflow;

    always #5 clk = ~clk;

    eth_stream_tx #(.PAYLOAD_LEN(PAY), .IFG_CLKS(IFG), .LVL_W(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .fifo_level(fifo_level), .fifo_data(fifo_data),
        .fifo_empty(fifo_empty), .fifo_rd(fifo_rd), .cfg_src_mac(cfg_src_mac),
        .cfg_ethertype(cfg_ethertype), .mii_txd(mii_txd), .mii_tx_en(mii_tx_en),
        .err_underflow(err_underflow)
    );

    logic [7:0] fq[$];
    logic [7:0] popped[$];
    logic [7:0] rxb[$];
    bit  force_empty = 1'b0;
    bit  uf_expect = 1'b0;
    bit  sticky_expect = 1'b0;
    int  checks = 0;
    int  errors = 0;
    int  frames_started = 0;
    int  frames_done = 0;
    int  pops_frame = 0;
    logic rd_seen = 1'b0;
    bit  done_flag = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic upd();
        fifo_level = LW'(fq.size());
        fifo_data  = (fq.size() > 0) ? fq[0] : 8'h00;
        fifo_empty = force_empty || (fq.size() == 0);
    endtask

    function automatic logic [31:0] crc_of(input logic [7:0] b[$], input int from, input int n);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = from; i < from + n; i++) begin
            c = c ^ {24'h0, b[i]};
            for (int k = 0; k < 8; k++) begin
                c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
            end
        end
        return c;
    endfunction

    // FIFO model: pop takes effect just after the edge that consumed it.
    always @(negedge clk) rd_seen <= fifo_rd;
    always @(posedge clk) begin
        #1;
        if (rd_seen && fq.size() > 0) begin
            popped.push_back(fq.pop_front());
            pops_frame++;
        end
        upd();
    end

    task automatic push(input int n);
        @(posedge clk);
        #2;
        for (int i = 0; i < n; i++) fq.push_back(8'($urandom));
        upd();
    endtask

    task automatic set_cfg();
        @(posedge clk);
        #2;
        cfg_src_mac   = {16'($urandom), 32'($urandom)};
        cfg_ethertype = 16'($urandom);
    endtask

    task automatic analyze();
        int n;
        bit ok;
        logic [31:0] crc;
        logic [31:0] fcs_rx;
        logic [7:0]  exp_b;
        n = rxb.size();
        chk(n == PAY + 26, "R3", "frame byte count", n, PAY + 26);
        if (n != PAY + 26) return;
        ok = 1'b1;
        for (int i = 0; i < 7; i++) if (rxb[i] != 8'h55) ok = 1'b0;
        chk(ok && rxb[7] == 8'hD5, "R3", "preamble/SFD", rxb[7], 8'hD5);
        ok = 1'b1;
        for (int i = 0; i < 14; i++) begin
            if (i < 6) exp_b = 8'hFF;
            else if (i < 12) exp_b = cfg_src_mac[47 - 8*(i-6) -: 8];
            else if (i == 12) exp_b = cfg_ethertype[15:8];
            else exp_b = cfg_ethertype[7:0];
            if (rxb[8+i] != exp_b) ok = 1'b0;
        end
        chk(ok, "R4", "header bytes", rxb[14], cfg_src_mac[47:40]);
        crc    = crc_of(rxb, 8, 14 + PAY);
        fcs_rx = {rxb[n-1], rxb[n-2], rxb[n-3], rxb[n-4]};
        if (uf_expect) begin
            chk(err_underflow == 1'b1, "R8", "underflow flag", err_underflow, 1);
            chk(fcs_rx == crc, "R8", "corrupted FCS", fcs_rx, crc);
            chk(pops_frame == PAY - 3, "R8", "pops with starved bytes", pops_frame, PAY - 3);
            popped.delete();
            uf_expect = 1'b0;
            sticky_expect = 1'b1;
        end else begin
            ok = (popped.size() >= PAY);
            for (int i = 0; i < PAY && ok; i++) if (rxb[22+i] != popped[i]) ok = 1'b0;
            chk(ok, "R5", "payload order", rxb[22], (popped.size() > 0) ? popped[0] : 0);
            chk(pops_frame == PAY, "R5", "pops per frame", pops_frame, PAY);
            for (int i = 0; i < PAY && popped.size() > 0; i++) void'(popped.pop_front());
            chk(fcs_rx == ~crc, "R6", "FCS", fcs_rx, ~crc);
            if (sticky_expect)
                chk(err_underflow == 1'b1, "R9", "flag still set", err_underflow, 1);
            else
                chk(err_underflow == 1'b0, "R8", "no spurious flag", err_underflow, 0);
        end
    endtask

    // Line monitor, sampled on the falling edge.
    bit         prev_en = 1'b0;
    bit         half = 1'b0;
    bit         seen_any = 1'b0;
    bit         exact_gap = 1'b0;
    logic [3:0] lo_nib = 4'h0;
    int         low_cnt = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (mii_tx_en) begin
                if (!prev_en) begin
                    frames_started++;
                    if (seen_any) begin
                        chk(low_cnt >= IFG, "R7", "minimum gap", low_cnt, IFG);
                        if (exact_gap)
                            chk(low_cnt == IFG + 1, "R7", "back-to-back gap", low_cnt, IFG + 1);
                    end
                    rxb.delete();
                    half = 1'b0;
                    pops_frame = 0;
                end
                if (!half) lo_nib = mii_txd;
                else rxb.push_back({mii_txd, lo_nib});
                half = ~half;
            end else begin
                if (prev_en) begin
                    analyze();
                    frames_done++;
                    seen_any  = 1'b1;
                    low_cnt   = 0;
                    exact_gap = (fq.size() >= PAY);
                end
                low_cnt++;
            end
            prev_en = mii_tx_en;
        end
    end

    task automatic wait_frames(input int target);
        while (frames_done < target) @(posedge clk);
    endtask

    task automatic finish_all();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_all();
    end

    initial begin
        int left;
        int k;
        void'($urandom(32'd20240611));
        upd();
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(mii_tx_en == 0 && mii_txd == 0, "R1", "reset line state", {mii_tx_en, mii_txd}, 0);
        chk(fifo_rd == 0 && err_underflow == 0, "R1", "reset pop/flag", {fifo_rd, err_underflow}, 0);
        @(posedge clk);
        #2 rst_n = 1'b1;

        // R2: one byte short of a payload never starts a frame
        set_cfg();
        push(PAY - 1);
        repeat (200) @(posedge clk);
        chk(frames_started == 0, "R2", "no start below threshold", frames_started, 0);
        push(1);
        wait_frames(1);

        // Random frames with bytes trickling in
        for (int f = 0; f < 6; f++) begin
            repeat (30) @(posedge clk);
            set_cfg();
            left = PAY;
            while (left > 0) begin
                k = 1 + int'($urandom % 20);
                if (k > left) k = left;
                push(k);
                left -= k;
                repeat (int'($urandom % 30)) @(posedge clk);
            end
            wait_frames(frames_done + 1);
        end

        // Back-to-back frames (R7 exact gap)
        repeat (30) @(posedge clk);
        set_cfg();
        push(3 * PAY);
        wait_frames(frames_done + 3);

        // R8: starve the payload for six clocks
        repeat (30) @(posedge clk);
        set_cfg();
        uf_expect = 1'b1;
        k = frames_started;
        push(PAY);
        while (frames_started == k) @(posedge clk);
        repeat (54) @(posedge clk);
        #2 force_empty = 1'b1;
        upd();
        repeat (6) @(posedge clk);
        #2 force_empty = 1'b0;
        upd();
        wait_frames(frames_done + 1);

        // R9: later frames are clean while the flag stays set
        repeat (30) @(posedge clk);
        push(PAY);
        wait_frames(frames_done + 1);
        repeat (40) @(posedge clk);
        chk(err_underflow == 1'b1, "R9", "flag held while idle", err_underflow, 1);
        finish_all();
    end
endmodule